// File: doc/BRIEF.md
# Lockstep SIMD Thread Core

This block is a small compute core that runs one kernel over a fixed group of thread lanes in lockstep. A single program counter, fetch stage and decoder are shared by all lanes. Each lane owns a register file, an arithmetic unit and a load/store port. One 16-bit instruction is fetched from an instruction memory port, decoded, and then applied to every active lane.

Loads and stores leave through one valid/ready request port per lane, and that memory may take any number of cycles to answer. The core steps through a fixed sequence of states for each instruction: fetch, decode, request, wait, execute, update. It leaves the wait state only when every active lane's request has been answered. Conditional branches are decided by a three-bit sign-flag register that a compare writes. After a return instruction the core raises `done` and stops fetching.

A host loads the kernel into instruction memory, sets the block index, the block size and the number of active lanes, and pulses `start`. It reads results from data memory once `done` is high.

Top module: `simd_core`

## Requirements
- R1: After reset `done` is low, no lane drives a memory request, and the instruction address is 0.
- R2: An instruction is split as opcode [15:12], destination [11:8], first source [7:4] and second source [3:0]. Opcodes are: 0 no-op, 1 branch, 2 compare, 3 add, 4 subtract, 5 multiply, 6 divide, 7 load, 8 store, 9 constant, 15 return. The no-op opcode and the unused opcodes 10 to 14 change no register and no flag, and only advance the program counter by one.
- R3: A compare treats both sources as signed 8-bit values and sets exactly one of the flag bits: negative at bit 2 (first source below second), zero at bit 1 (equal), positive at bit 0 (first source above second).
- R4: A branch carries a condition mask in bits [11:9], with the same bit order as the flags, and an absolute target in bits [7:0]. The branch is taken when the mask and lane 0's flags share a set bit. Otherwise the program counter advances by one.
- R5: Add, subtract, multiply and divide write the destination in every active lane. Results wrap modulo 256. Division is unsigned, and division by zero writes 0.
- R6: The constant opcode writes bits [7:0] of the instruction into the destination register.
- R7: A load reads data memory at the address held in the first source and writes the result to the destination. A store writes the second source to the address held in the first source. A request stays asserted, with its address, direction and data held, until the memory answers with ready.
- R8: Execution does not resume until every active lane's request has completed. Lanes at or above the latched thread count issue no request and write no register.
- R9: Registers 13, 14 and 15 read as the block index, the block size and the lane's own index. Writes to them are ignored.
- R10: When a return executes, `done` rises and fetching stops. `done` stays high and the instruction address stays fixed until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the kernel from address 0 while idle |
| thread_count | input | CNT_W | Number of active lanes, latched at start |
| block_idx | input | DATA_W | Value read from register 13 |
| block_dim | input | DATA_W | Value read from register 14 |
| imem_addr | output | PC_W | Instruction address (the program counter) |
| imem_data | input | 16 | Instruction word at imem_addr |
| mem_req_valid | output | NUM_LANES | Per-lane memory request valid |
| mem_req_we | output | NUM_LANES | Per-lane request is a store |
| mem_req_addr | output | NUM_LANES*DATA_W | Per-lane request address |
| mem_req_wdata | output | NUM_LANES*DATA_W | Per-lane store data |
| mem_rsp_ready | input | NUM_LANES | Per-lane request completion |
| mem_rsp_rdata | input | NUM_LANES*DATA_W | Per-lane load data, valid with ready |
| done | output | 1 | Kernel has returned |

## Verification
The bench builds the core with its defaults: four lanes, 8-bit data and an 8-bit program counter. At that size, a grid of 64 operand pairs is run across every thread count from one to four. With the per-lane operand offsets, this covers signed and unsigned wrap, division by zero, and all three compare outcomes. The same size also lets every lane's results and every idle lane's untouched memory be checked after each run. The memory model varies its answer latency per lane and per request, so the drain condition of the wait state is exercised with lanes finishing in different orders. Loop kernels with trip counts from one to six exercise backward branches.

// File: rtl/simd_core_pkg.sv
package simd_core_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_BR    = 4'd1,
    OP_CMP   = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_MUL   = 4'd5,
    OP_DIV   = 4'd6,
    OP_LDR   = 4'd7,
    OP_STR   = 4'd8,
    OP_CONST = 4'd9,
    OP_RET   = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_REQUEST,
    S_WAIT,
    S_EXECUTE,
    S_UPDATE
  } core_state_e;

  typedef enum logic [2:0] {
    WB_ADD,
    WB_SUB,
    WB_MUL,
    WB_DIV,
    WB_IMM,
    WB_LOAD
  } wb_sel_e;

  localparam int          INSTR_W     = 16;
  localparam int          NUM_REGS    = 16;
  localparam logic [3:0]  REG_BLK_IDX = 4'd13;
  localparam logic [3:0]  REG_BLK_DIM = 4'd14;
  localparam logic [3:0]  REG_THREAD  = 4'd15;

  typedef struct packed {
    logic [3:0] rd;
    logic [3:0] rs;
    logic [3:0] rt;
    logic [7:0] imm;
    logic       wr_reg;
    logic       use_mem;
    logic       mem_wr;
    logic       is_cmp;
    wb_sel_e    wb;
  } lane_ctrl_t;

  typedef struct packed {
    lane_ctrl_t lane;
    logic [2:0] nzp_mask;
    logic [7:0] target;
    logic       is_branch;
    logic       is_ret;
  } core_ctrl_t;

endpackage

// File: rtl/simd_decoder.sv
module simd_decoder
  import simd_core_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output core_ctrl_t         ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.lane.rd  = instr[11:8];
    ctrl.lane.rs  = instr[7:4];
    ctrl.lane.rt  = instr[3:0];
    ctrl.lane.imm = instr[7:0];
    ctrl.nzp_mask = instr[11:9];
    ctrl.target   = instr[7:0];
    case (opcode_e'(instr[15:12]))
      OP_BR:    ctrl.is_branch = 1'b1;
      OP_CMP:   ctrl.lane.is_cmp = 1'b1;
      OP_ADD:   begin ctrl.lane.wr_reg = 1'b1; ctrl.lane.wb = WB_ADD; end
      OP_SUB:   begin ctrl.lane.wr_reg = 1'b1; ctrl.lane.wb = WB_SUB; end
      OP_MUL:   begin ctrl.lane.wr_reg = 1'b1; ctrl.lane.wb = WB_MUL; end
      OP_DIV:   begin ctrl.lane.wr_reg = 1'b1; ctrl.lane.wb = WB_DIV; end
      OP_CONST: begin ctrl.lane.wr_reg = 1'b1; ctrl.lane.wb = WB_IMM; end
      OP_LDR: begin
        ctrl.lane.wr_reg  = 1'b1;
        ctrl.lane.use_mem = 1'b1;
        ctrl.lane.wb      = WB_LOAD;
      end
      OP_STR: begin
        ctrl.lane.use_mem = 1'b1;
        ctrl.lane.mem_wr  = 1'b1;
      end
      OP_RET:   ctrl.is_ret = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_core_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LANE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              issue,
  input  logic              commit,
  input  lane_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] block_idx,
  input  logic [DATA_W-1:0] block_dim,
  output logic [2:0]        nzp,
  output logic              req_valid,
  output logic              req_we,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] rf [NUM_REGS];
  logic [DATA_W-1:0] rs_val, rt_val, wb_val, load_q;
  logic              lt, eq;

  // read ports: the top three indices are identity values, not storage
  always_comb begin
    case (ctrl.rs)
      REG_BLK_IDX: rs_val = block_idx;
      REG_BLK_DIM: rs_val = block_dim;
      REG_THREAD:  rs_val = DATA_W'(LANE_ID);
      default:     rs_val = rf[ctrl.rs];
    endcase
    case (ctrl.rt)
      REG_BLK_IDX: rt_val = block_idx;
      REG_BLK_DIM: rt_val = block_dim;
      REG_THREAD:  rt_val = DATA_W'(LANE_ID);
      default:     rt_val = rf[ctrl.rt];
    endcase
  end

  always_comb begin
    case (ctrl.wb)
      WB_ADD:  wb_val = rs_val + rt_val;
      WB_SUB:  wb_val = rs_val - rt_val;
      WB_MUL:  wb_val = rs_val * rt_val;
      WB_DIV:  wb_val = (rt_val == '0) ? '0 : rs_val / rt_val;
      WB_IMM:  wb_val = DATA_W'(ctrl.imm);
      WB_LOAD: wb_val = load_q;
      default: wb_val = '0;
    endcase
  end

  // register file: one write port, no reset, so it maps onto LUT RAM
  always_ff @(posedge clk) begin
    if (commit && active && ctrl.wr_reg && (ctrl.rd < REG_BLK_IDX))
      rf[ctrl.rd] <= wb_val;
  end

  assign lt = $signed(rs_val) < $signed(rt_val);
  assign eq = (rs_val == rt_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      nzp <= 3'b000;
    end else if (commit && active && ctrl.is_cmp) begin
      nzp <= {lt, eq, !lt && !eq};
    end
  end

  // load/store sequencing: issue in REQUEST, hold until ready
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      load_q    <= '0;
    end else if (issue && active && ctrl.use_mem) begin
      req_valid <= 1'b1;
      req_we    <= ctrl.mem_wr;
      req_addr  <= rs_val;
      req_wdata <= rt_val;
    end else if (req_valid && rsp_ready) begin
      req_valid <= 1'b0;
      if (!req_we) load_q <= rsp_rdata;
    end
  end

  a_r3_cmp_onehot: assert property (@(posedge clk) disable iff (rst)
    (commit && active && ctrl.is_cmp) |=> ($countones(nzp) == 1));

  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_ready) |=> (req_valid && $stable(req_addr) && $stable(req_we) && $stable(req_wdata)));

  a_r8_idle_lane_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> !req_valid);

endmodule

// File: rtl/simd_core.sv
module simd_core
  import simd_core_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  parameter int PC_W      = 8,
  localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [CNT_W-1:0]            thread_count,
  input  logic [DATA_W-1:0]           block_idx,
  input  logic [DATA_W-1:0]           block_dim,
  output logic [PC_W-1:0]             imem_addr,
  input  logic [INSTR_W-1:0]          imem_data,
  output logic [NUM_LANES-1:0]        mem_req_valid,
  output logic [NUM_LANES-1:0]        mem_req_we,
  output logic [NUM_LANES*DATA_W-1:0] mem_req_addr,
  output logic [NUM_LANES*DATA_W-1:0] mem_req_wdata,
  input  logic [NUM_LANES-1:0]        mem_rsp_ready,
  input  logic [NUM_LANES*DATA_W-1:0] mem_rsp_rdata,
  output logic                        done
);

  core_state_e          state_q;
  logic [PC_W-1:0]      pc_q;
  logic [INSTR_W-1:0]   instr_q;
  core_ctrl_t           ctrl_d, ctrl_q;
  logic [CNT_W-1:0]     tc_q;
  logic                 done_q;
  logic [NUM_LANES*3-1:0] lane_nzp;
  logic                 take_branch;

  simd_decoder u_dec (
    .instr (instr_q),
    .ctrl  (ctrl_d)
  );

  // branch decisions follow lane 0's flags only
  assign take_branch = ctrl_q.is_branch && ((ctrl_q.nzp_mask & lane_nzp[2:0]) != 3'b000);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      instr_q <= '0;
      ctrl_q  <= '0;
      tc_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          pc_q    <= '0;
          done_q  <= 1'b0;
          tc_q    <= thread_count;
          state_q <= S_FETCH;
        end
        S_FETCH: begin
          instr_q <= imem_data;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          ctrl_q  <= ctrl_d;
          state_q <= S_REQUEST;
        end
        S_REQUEST: state_q <= S_WAIT;
        S_WAIT:    if (mem_req_valid == '0) state_q <= S_EXECUTE;
        S_EXECUTE: state_q <= S_UPDATE;
        S_UPDATE: begin
          if (ctrl_q.is_ret) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            pc_q    <= take_branch ? PC_W'(ctrl_q.target) : pc_q + PC_W'(1);
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign imem_addr = pc_q;
  assign done      = done_q;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    simd_lane #(
      .DATA_W  (DATA_W),
      .LANE_ID (i)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .active    (tc_q > CNT_W'(i)),
      .issue     (state_q == S_REQUEST),
      .commit    (state_q == S_EXECUTE),
      .ctrl      (ctrl_q.lane),
      .block_idx (block_idx),
      .block_dim (block_dim),
      .nzp       (lane_nzp[i*3 +: 3]),
      .req_valid (mem_req_valid[i]),
      .req_we    (mem_req_we[i]),
      .req_addr  (mem_req_addr[i*DATA_W +: DATA_W]),
      .req_wdata (mem_req_wdata[i*DATA_W +: DATA_W]),
      .rsp_ready (mem_rsp_ready[i]),
      .rsp_rdata (mem_rsp_rdata[i*DATA_W +: DATA_W])
    );

    a_r3_flags_legal: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lane_nzp[i*3 +: 3]));
  end

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (mem_req_valid == '0));

  a_r8_exec_after_drain: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_EXECUTE) |-> (mem_req_valid == '0));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_UPDATE && !ctrl_q.is_branch && !ctrl_q.is_ret) |=> (pc_q == $past(pc_q) + PC_W'(1)));

  a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(pc_q)));

endmodule

// File: tb/simd_core_tb.sv
`timescale 1ns/1ps
module simd_core_tb;

  localparam int NL = 4;
  localparam int DW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [2:0]     thread_count = 3'd4;
  logic [7:0]     block_idx = '0, block_dim = '0;
  logic [7:0]     imem_addr;
  logic [15:0]    imem_data;
  logic [NL-1:0]  mem_req_valid, mem_req_we, mem_rsp_ready;
  logic [NL*DW-1:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic           done;

  logic [15:0] imem [256];
  logic [7:0]  dmem [256];
  int n_cmp = 0, n_bad = 0, cyc = 0, inact_hits = 0, cur_tc = 4;
  int wcnt [NL];
  int nreq [NL];

  always #4 clk = ~clk;

  assign imem_data = imem[imem_addr];

  simd_core u_dut (
    .clk(clk), .rst(rst), .start(start), .thread_count(thread_count),
    .block_idx(block_idx), .block_dim(block_dim),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_rdata(mem_rsp_rdata),
    .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory with per-lane, per-request latency
  initial begin
    mem_rsp_ready = '0;
    mem_rsp_rdata = '0;
    for (int l = 0; l < NL; l++) begin wcnt[l] = 0; nreq[l] = 0; end
    forever begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        if (mem_rsp_ready[l]) mem_rsp_ready[l] = 1'b0;
        else if (mem_req_valid[l]) begin
          if (l >= cur_tc) inact_hits++;
          if (wcnt[l] >= (l + nreq[l]) % 4) begin
            if (mem_req_we[l]) dmem[mem_req_addr[l*DW +: DW]] = mem_req_wdata[l*DW +: DW];
            else mem_rsp_rdata[l*DW +: DW] = dmem[mem_req_addr[l*DW +: DW]];
            mem_rsp_ready[l] = 1'b1;
            wcnt[l] = 0;
            nreq[l]++;
          end else wcnt[l]++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL R10 watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  function automatic logic [15:0] op3(input int op, input int rd, input int rs, input int rt);
    return {4'(op), 4'(rd), 4'(rs), 4'(rt)};
  endfunction
  function automatic logic [15:0] cst(input int rd, input int imm);
    return {4'd9, 4'(rd), 8'(imm)};
  endfunction
  function automatic logic [15:0] br(input int mask, input int tgt);
    return {4'd1, 3'(mask), 1'b0, 8'(tgt)};
  endfunction

  task automatic clear_mem();
    for (int k = 0; k < 256; k++) begin dmem[k] = 8'hEE; imem[k] = 16'hF000; end
  endtask

  task automatic launch(input int tc, input int bidx, input int bdim);
    thread_count = 3'(tc); cur_tc = tc;
    block_idx = 8'(bidx); block_dim = 8'(bdim);
    inact_hits = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    logic [7:0] pc_at;
    while (!done && k < 4000) begin @(negedge clk); k++; end
    chk("R10", "done raised", int'(done), 1);
    pc_at = imem_addr;
    repeat (4) @(negedge clk);
    chk("R10", "fetch halted", int'(imem_addr == pc_at && done && mem_req_valid == '0), 1);
  endtask

  task automatic run_arith(input logic [7:0] a, input logic [7:0] b, input int tc, input int bidx, input int bdim);
    logic [7:0] exp_v [8];
    logic [7:0] at, bt;
    int flag;
    int regs [8] = '{3, 4, 5, 6, 12, 13, 14, 15};
    clear_mem();
    imem[0] = cst(9, 128);       imem[1] = op3(3, 9, 9, 15);
    imem[2] = op3(7, 1, 9, 0);   imem[3] = cst(2, b);
    imem[4] = op3(4, 2, 2, 15);  imem[5] = 16'h0000;
    imem[6] = 16'hA2FF;          imem[7] = op3(3, 3, 1, 2);
    imem[8] = op3(4, 4, 1, 2);   imem[9] = op3(5, 5, 1, 2);
    imem[10] = op3(6, 6, 1, 2);  imem[11] = op3(2, 0, 1, 2);
    imem[12] = br(3'b100, 16);   imem[13] = br(3'b010, 18);
    imem[14] = cst(12, 3);       imem[15] = br(3'b111, 19);
    imem[16] = cst(12, 1);       imem[17] = br(3'b111, 19);
    imem[18] = cst(12, 2);       imem[19] = cst(13, 77);
    imem[20] = cst(15, 99);      imem[21] = cst(7, 8);
    imem[22] = op3(5, 10, 15, 7); imem[23] = cst(11, 1);
    for (int k = 0; k < 8; k++) begin
      imem[24 + 2*k] = op3(8, 0, 10, regs[k]);
      imem[25 + 2*k] = op3(3, 10, 10, 11);
    end
    for (int t = 0; t < NL; t++) dmem[128 + t] = a + 8'(61 * t);
    if ($signed(a) < $signed(b)) flag = 1;
    else if (a == b) flag = 2;
    else flag = 3;
    launch(tc, bidx, bdim);
    wait_done();
    for (int t = 0; t < NL; t++) begin
      at = a + 8'(61 * t);
      bt = b - 8'(t);
      exp_v[0] = at + bt; exp_v[1] = at - bt; exp_v[2] = at * bt;
      exp_v[3] = (bt == 0) ? 8'd0 : at / bt;
      exp_v[4] = 8'(flag); exp_v[5] = 8'(bidx); exp_v[6] = 8'(bdim); exp_v[7] = 8'(t);
      if (t < tc) begin
        chk("R7", "load+store path add", int'(dmem[t*8+0]), int'(exp_v[0]));
        chk("R5", "sub wrap", int'(dmem[t*8+1]), int'(exp_v[1]));
        chk("R5", "mul wrap", int'(dmem[t*8+2]), int'(exp_v[2]));
        chk("R5", "div / div-by-zero", int'(dmem[t*8+3]), int'(exp_v[3]));
        chk("R4", "lane-0 flag branch (R3 R6 R2)", int'(dmem[t*8+4]), int'(exp_v[4]));
        chk("R9", "block index read-only", int'(dmem[t*8+5]), int'(exp_v[5]));
        chk("R9", "block size", int'(dmem[t*8+6]), int'(exp_v[6]));
        chk("R9", "thread index read-only", int'(dmem[t*8+7]), int'(exp_v[7]));
      end else begin
        chk("R8", "idle lane memory untouched", int'(dmem[t*8+0] == 8'hEE && dmem[t*8+7] == 8'hEE), 1);
      end
    end
    chk("R8", "idle lanes issued no request", inact_hits, 0);
  endtask

  task automatic run_loop(input int n);
    int e;
    clear_mem();
    imem[0] = cst(1, 0);  imem[1] = cst(2, 0);
    imem[2] = cst(3, n);  imem[3] = cst(4, 1);
    imem[4] = op3(3, 1, 1, 2);  imem[5] = op3(3, 1, 1, 15);
    imem[6] = op3(3, 2, 2, 4);  imem[7] = op3(2, 0, 2, 3);
    imem[8] = br(3'b100, 4);    imem[9] = cst(5, 64);
    imem[10] = op3(3, 5, 5, 15); imem[11] = op3(8, 0, 5, 1);
    launch(4, 0, 4);
    wait_done();
    for (int t = 0; t < NL; t++) begin
      e = (n * (n - 1) / 2 + n * t) % 256;
      chk("R4", "backward branch loop sum", int'(dmem[64 + t]), e);
    end
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "no request after reset", int'(mem_req_valid), 0);
    chk("R1", "fetch address after reset", int'(imem_addr), 0);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [7:0] a, b;
        a = 8'((i * 73) % 256);
        b = (i == j) ? a : 8'((j * 73 + 1) % 256);
        run_arith(a, b, ((i + j) % 4) + 1, i * 8 + j, ((i + j) % 4) + 11);
      end
    end
    for (int n = 1; n <= 6; n++) run_loop(n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule